// File: doc/BRIEF.md
# Serial Configuration Loader with Startup Sequencer

This block stands for the configuration side of a programmable device. Once an external enable line is high, it takes a fixed-length bitstream one bit at a time from a serial source. The source supplies its own serial clock. After the last expected bit has arrived, the block raises a completion flag. That flag also serves as the source's select line, so the source has to stop sending. Bit contents are not checked. The block keeps the most recent bits it received so that they can be observed.

When the completion flag rises, it is carried into the startup clock domain through a small synchronizer. A startup phase of fixed length (299 cycles by default) then runs on one of two clocks: a free-running internal oscillator, or a user-supplied clock chosen with a static select pin. At the end of that phase a user-mode output rises, and it stays high until reset. If the user clock is selected and held still, the device stays in startup for as long as the clock is held.

The serial input is a valid/ready stream clocked by `sclk`. The source drives `bit_data` with `bit_valid`. A bit moves on a rising `sclk` edge only when `bit_valid` and `bit_ready` are both high. The source must hold the bit while `bit_ready` is low. `bit_ready` is low until the enable has been seen, low while the enable is low, and stays low for good once the completion flag is up.

Top module: `cfg_loader_top`

## Requirements
- R1: A bit is accepted on a rising `sclk` edge exactly when `bit_valid` and `bit_ready` are both high, and each accepted bit raises `rx_count` by one; `bit_ready` is high only while receiving and `bit_status` is high.
- R2: Before `bit_status` has been seen high on an `sclk` edge, `bit_ready` is low and no bit is accepted.
- R3: `cfg_done` rises on the `sclk` edge that accepts bit number BITS and never earlier; while it is high, `rx_count` equals BITS.
- R4: Once `cfg_done` is high, `bit_ready` is low and further `sclk` edges with `bit_valid` high change neither `rx_count` nor `frame_tail`.
- R5: `frame_tail` holds the last TAIL_W accepted bits, with the newest in bit 0 and older bits shifted toward the MSB.
- R6: `init_done` rises on the startup-clock rising edge numbered INIT_CYCLES+2, counting from the first startup-clock edge after `cfg_done` rose. Two of those edges belong to the synchronizer and INIT_CYCLES (default 299) to the startup count.
- R7: With `usr_sel`=0 the startup clock is `osc_clk`. With `usr_sel`=1 it is `usr_clk`, and while `usr_clk` has no edges `init_done` stays low no matter how many `osc_clk` edges occur.
- R8: `init_term` is high exactly when the startup count has reached INIT_CYCLES, so it rises on the same edge as `init_done`.
- R9: A synchronous `rst` clears the bit count, `frame_tail`, `cfg_done`, the startup count, `init_term` and `init_done`. Outside reset, `init_done` never falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous reset, sampled in both clock domains |
| osc_clk | input | 1 | Internal oscillator clock for startup |
| usr_clk | input | 1 | Optional user startup clock |
| usr_sel | input | 1 | Static select: 1 runs startup on `usr_clk` |
| sclk | input | 1 | Serial configuration clock |
| bit_status | input | 1 | Enable; reception proceeds only while high |
| bit_valid | input | 1 | Source has a bit on `bit_data` |
| bit_data | input | 1 | Serial configuration bit |
| bit_ready | output | 1 | Block can take a bit on the next `sclk` rise |
| cfg_done | output | 1 | Full bitstream received; deselects the source |
| rx_count | output | $clog2(BITS+1) | Number of bits accepted |
| frame_tail | output | TAIL_W | Most recent accepted bits, newest in bit 0 |
| init_term | output | 1 | Startup count has reached its terminal value |
| init_done | output | 1 | Startup finished; user mode |

## Verification
On every clock cycle, the assertions check these behaviours: the count steps by one per handshake, nothing moves without a handshake, `bit_ready` is closed while the enable is low and after completion, completion only ever appears with a full count, and in the startup domain `init_done` is sticky, comes with `init_term` and follows `cfg_done`. Some behaviours can only be shown by the bench's scenarios: the exact number of startup edges between completion and user mode on each clock choice, the indefinite stall with a frozen user clock, the tail contents after random gaps and enable drops, and a reset that lands in the middle of startup.

// File: rtl/cfg_loader_pkg.sv
`timescale 1ns/1ps
package cfg_loader_pkg;
  typedef enum logic [1:0] {
    SER_RESET = 2'd0,
    SER_WAIT  = 2'd1,
    SER_RECV  = 2'd2,
    SER_DONE  = 2'd3
  } ser_state_e;

  typedef enum logic [1:0] {
    INI_IDLE  = 2'd0,
    INI_COUNT = 2'd1,
    INI_USER  = 2'd2
  } ini_state_e;
endpackage

// File: rtl/cfg_rx_serial.sv
`timescale 1ns/1ps
module cfg_rx_serial
  import cfg_loader_pkg::*;
#(
  parameter int BITS   = 1024,
  parameter int TAIL_W = 16,
  localparam int CNT_W = $clog2(BITS + 1)
) (
  input  logic              sclk,
  input  logic              rst,
  input  logic              bit_status,
  input  logic              bit_valid,
  input  logic              bit_data,
  output logic              bit_ready,
  output logic              cfg_done,
  output logic [CNT_W-1:0]  rx_count,
  output logic [TAIL_W-1:0] frame_tail
);
  ser_state_e st;
  logic       take;

  assign bit_ready = (st == SER_RECV) && bit_status;
  assign cfg_done  = (st == SER_DONE);
  assign take      = bit_valid && bit_ready;

  always_ff @(posedge sclk) begin
    if (rst) begin
      st       <= SER_RESET;
      rx_count <= '0;
    end else begin
      case (st)
        SER_RESET: st <= SER_WAIT;
        SER_WAIT:  if (bit_status) st <= SER_RECV;
        SER_RECV: begin
          if (take) begin
            rx_count <= rx_count + 1'b1;
            if (rx_count == CNT_W'(BITS - 1)) st <= SER_DONE;
          end
        end
        default: st <= SER_DONE;
      endcase
    end
  end

  generate
    if (TAIL_W > 1) begin : g_tail_shift
      always_ff @(posedge sclk) begin
        if (rst)       frame_tail <= '0;
        else if (take) frame_tail <= {frame_tail[TAIL_W-2:0], bit_data};
      end
    end else begin : g_tail_single
      always_ff @(posedge sclk) begin
        if (rst)       frame_tail <= '0;
        else if (take) frame_tail <= bit_data;
      end
    end
  endgenerate
endmodule

// File: rtl/cfg_sync.sv
`timescale 1ns/1ps
module cfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cfg_clk_sel.sv
`timescale 1ns/1ps
module cfg_clk_sel (
  input  logic osc_clk,
  input  logic usr_clk,
  input  logic usr_sel,
  output logic init_clk
);
  always_comb init_clk = usr_sel ? usr_clk : osc_clk;
endmodule

// File: rtl/cfg_init_seq.sv
`timescale 1ns/1ps
module cfg_init_seq
  import cfg_loader_pkg::*;
#(
  parameter int INIT_CYCLES = 299,
  localparam int CW = $clog2(INIT_CYCLES + 1)
) (
  input  logic init_clk,
  input  logic rst,
  input  logic done_s,
  output logic init_term,
  output logic init_done
);
  ini_state_e    st;
  logic [CW-1:0] cnt;

  always_ff @(posedge init_clk) begin
    if (rst) begin
      st  <= INI_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        INI_IDLE: begin
          if (done_s) begin
            cnt <= CW'(1);
            st  <= (INIT_CYCLES == 1) ? INI_USER : INI_COUNT;
          end
        end
        INI_COUNT: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(INIT_CYCLES - 1)) st <= INI_USER;
        end
        default: st <= INI_USER;
      endcase
    end
  end

  assign init_done = (st == INI_USER);
  assign init_term = (cnt == CW'(INIT_CYCLES));
endmodule

// File: rtl/cfg_loader_top.sv
`timescale 1ns/1ps
module cfg_loader_top #(
  parameter int BITS        = 1024,
  parameter int TAIL_W      = 16,
  parameter int INIT_CYCLES = 299,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(BITS + 1)
) (
  input  logic              rst,
  input  logic              osc_clk,
  input  logic              usr_clk,
  input  logic              usr_sel,
  input  logic              sclk,
  input  logic              bit_status,
  input  logic              bit_valid,
  input  logic              bit_data,
  output logic              bit_ready,
  output logic              cfg_done,
  output logic [CNT_W-1:0]  rx_count,
  output logic [TAIL_W-1:0] frame_tail,
  output logic              init_term,
  output logic              init_done
);
  logic init_clk;
  logic done_s;

  cfg_rx_serial #(.BITS(BITS), .TAIL_W(TAIL_W)) rx_i (
    .sclk(sclk), .rst(rst), .bit_status(bit_status), .bit_valid(bit_valid),
    .bit_data(bit_data), .bit_ready(bit_ready), .cfg_done(cfg_done),
    .rx_count(rx_count), .frame_tail(frame_tail)
  );

  cfg_clk_sel sel_i (
    .osc_clk(osc_clk), .usr_clk(usr_clk), .usr_sel(usr_sel), .init_clk(init_clk)
  );

  cfg_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(init_clk), .rst(rst), .d(cfg_done), .q(done_s)
  );

  cfg_init_seq #(.INIT_CYCLES(INIT_CYCLES)) init_i (
    .init_clk(init_clk), .rst(rst), .done_s(done_s),
    .init_term(init_term), .init_done(init_done)
  );
endmodule

// File: rtl/cfg_loader_chk.sv
`timescale 1ns/1ps
module cfg_loader_chk #(
  parameter int BITS   = 1024,
  parameter int TAIL_W = 16,
  parameter int CNT_W  = 11
) (
  input logic              rst,
  input logic              sclk,
  input logic              init_clk,
  input logic              bit_status,
  input logic              bit_valid,
  input logic              bit_ready,
  input logic              cfg_done,
  input logic [CNT_W-1:0]  rx_count,
  input logic [TAIL_W-1:0] frame_tail,
  input logic              init_term,
  input logic              init_done
);
  p_count_step_r1: assert property (@(posedge sclk) disable iff (rst)
    (bit_valid && bit_ready) |=> (rx_count == CNT_W'($past(rx_count) + 1'b1)));

  p_closed_no_status_r2: assert property (@(posedge sclk) disable iff (rst)
    !bit_status |-> !bit_ready);

  p_done_full_r3: assert property (@(posedge sclk) disable iff (rst)
    cfg_done |-> (rx_count == CNT_W'(BITS)));

  p_closed_after_done_r4: assert property (@(posedge sclk) disable iff (rst)
    cfg_done |-> !bit_ready);

  p_hold_no_xfer_r4: assert property (@(posedge sclk) disable iff (rst)
    !(bit_valid && bit_ready) |=> ($stable(rx_count) && $stable(frame_tail)));

  p_user_after_done_r6: assert property (@(posedge init_clk) disable iff (rst)
    init_done |-> cfg_done);

  p_term_with_user_r8: assert property (@(posedge init_clk) disable iff (rst)
    init_done |-> init_term);

  p_user_sticky_r9: assert property (@(posedge init_clk) disable iff (rst)
    init_done |=> init_done);
endmodule

bind cfg_loader_top cfg_loader_chk #(
  .BITS(BITS), .TAIL_W(TAIL_W), .CNT_W(CNT_W)
) chk_i (
  .rst(rst), .sclk(sclk), .init_clk(init_clk), .bit_status(bit_status),
  .bit_valid(bit_valid), .bit_ready(bit_ready), .cfg_done(cfg_done),
  .rx_count(rx_count), .frame_tail(frame_tail), .init_term(init_term),
  .init_done(init_done)
);

// File: tb/cfg_loader_top_tb_top.sv
`timescale 1ns/1ps
module cfg_loader_top_tb_top;
  localparam int BITS   = 40;
  localparam int TAIL_W = 8;
  localparam int INITC  = 299;
  localparam int CW     = $clog2(BITS + 1);

  logic osc_clk = 0, usr_clk = 0, sclk = 0, rst = 1, usr_sel = 0;
  logic bit_status = 0, bit_valid = 0, bit_data = 0, usr_run = 1;
  logic bit_ready, cfg_done, init_term, init_done;
  logic [CW-1:0]     rx_count;
  logic [TAIL_W-1:0] frame_tail;

  int checks = 0, fails = 0;
  int m_cnt;
  logic [TAIL_W-1:0] m_tail;

  cfg_loader_top #(.BITS(BITS), .TAIL_W(TAIL_W), .INIT_CYCLES(INITC)) dut_i (
    .rst(rst), .osc_clk(osc_clk), .usr_clk(usr_clk), .usr_sel(usr_sel),
    .sclk(sclk), .bit_status(bit_status), .bit_valid(bit_valid),
    .bit_data(bit_data), .bit_ready(bit_ready), .cfg_done(cfg_done),
    .rx_count(rx_count), .frame_tail(frame_tail), .init_term(init_term),
    .init_done(init_done)
  );

  always #5 osc_clk = ~osc_clk;

  always begin
    @(posedge osc_clk);
    if (usr_run) begin
      #2 usr_clk = 1;
      #3 usr_clk = 0;
    end
  end

  function automatic logic [TAIL_W-1:0] tail_next(logic [TAIL_W-1:0] t, logic d);
    return {t[TAIL_W-2:0], d};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse(input logic v, input logic d);
    @(negedge osc_clk);
    bit_valid = v;
    bit_data  = d;
    #1 sclk = 1;
    #2 sclk = 0;
  endtask

  task automatic do_reset();
    rst = 1; usr_run = 1; bit_valid = 0; bit_status = 0;
    repeat (4) pulse(0, 0);
    rst = 0;
    m_cnt = 0; m_tail = '0;
    chk(cfg_done == 0, "R9", "done after reset", int'(cfg_done), 0);
    chk(int'(rx_count) == 0, "R9", "count after reset", int'(rx_count), 0);
    chk(frame_tail == 0, "R9", "tail after reset", int'(frame_tail), 0);
    chk(init_done == 0, "R9", "init_done after reset", int'(init_done), 0);
    chk(init_term == 0, "R9", "init_term after reset", int'(init_term), 0);
    chk(bit_ready == 0, "R2", "ready after reset", int'(bit_ready), 0);
  endtask

  task automatic open_stream();
    pulse(0, 0);
    for (int i = 0; i < 3; i++) begin
      pulse(1, 1'($urandom % 2));
      chk(int'(rx_count) == 0, "R2", "count before status", int'(rx_count), 0);
      chk(bit_ready == 0, "R2", "ready before status", int'(bit_ready), 0);
    end
    bit_status = 1;
    pulse(0, 0);
    chk(bit_ready == 1, "R1", "ready once status seen", int'(bit_ready), 1);
  endtask

  task automatic load_stream();
    while (m_cnt < BITS) begin
      logic v, d, s;
      v = (($urandom % 100) < 75);
      d = 1'($urandom % 2);
      s = (($urandom % 100) >= 12);
      bit_status = s;
      #1;
      chk(bit_ready == s, "R1", "ready follows status", int'(bit_ready), int'(s));
      chk(cfg_done == 0, "R3", "done before full count", int'(cfg_done), 0);
      pulse(v, d);
      if (v && s) begin
        m_cnt++;
        m_tail = tail_next(m_tail, d);
      end
      chk(int'(rx_count) == m_cnt, "R1", "bit count", int'(rx_count), m_cnt);
      chk(frame_tail == m_tail, "R5", "tail", int'(frame_tail), int'(m_tail));
    end
    chk(cfg_done == 1, "R3", "done after full count", int'(cfg_done), 1);
  endtask

  task automatic measure(input bit use_usr, output int n);
    n = 0;
    while (n < 2000) begin
      if (use_usr) @(posedge usr_clk);
      else         @(posedge osc_clk);
      n++;
      #1;
      if (n == INITC + 1)
        chk(init_term == 0, "R8", "term one edge early", int'(init_term), 0);
      if (init_done) break;
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", checks + 1, fails);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'h5eed_c0f1));

    // Run 1: internal oscillator
    usr_sel = 0;
    do_reset();
    open_stream();
    load_stream();
    measure(0, n);
    chk(n == INITC + 2, "R6", "osc edges to user mode", n, INITC + 2);
    chk(init_term == 1, "R8", "term with user mode", int'(init_term), 1);
    for (int i = 0; i < 5; i++) begin
      pulse(1, 1'($urandom % 2));
      chk(int'(rx_count) == BITS, "R4", "count after done", int'(rx_count), BITS);
      chk(frame_tail == m_tail, "R4", "tail after done", int'(frame_tail), int'(m_tail));
      chk(bit_ready == 0, "R4", "ready after done", int'(bit_ready), 0);
    end
    repeat (50) @(posedge osc_clk);
    #1 chk(init_done == 1, "R9", "user mode sticky", int'(init_done), 1);

    // Run 2: user clock, stalled then released
    usr_sel = 1;
    do_reset();
    usr_run = 0;
    open_stream();
    load_stream();
    repeat (2000) @(posedge osc_clk);
    #1;
    chk(init_done == 0, "R7", "stalled user clock holds startup", int'(init_done), 0);
    chk(init_term == 0, "R7", "stalled user clock term", int'(init_term), 0);
    usr_run = 1;
    measure(1, n);
    chk(n == INITC + 2, "R6", "user edges to user mode", n, INITC + 2);
    chk(init_done == 1, "R7", "user clock startup completes", int'(init_done), 1);

    // Run 3: reset in the middle of startup
    usr_sel = 0;
    do_reset();
    open_stream();
    load_stream();
    repeat (100) @(posedge osc_clk);
    #1 chk(init_done == 0, "R6", "not yet in user mode", int'(init_done), 0);
    do_reset();

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule